// File: doc/BRIEF.md
# Serial Clock-Chip Register Loader

This block brings up an external clock-conditioning chip by writing a fixed burst of 32-bit register words over a three-wire serial link made of a clock, a data line and a latch-enable strobe. When a start pulse arrives while it is idle, it sends a built-in reset word first. It then sends eight configuration words. The block reads each configuration word from a configuration RAM as two 16-bit halves, upper half first, and joins the two halves before shifting the word out.

The serial clock is a divided copy of the system clock. With the default divider of 25, a 50 MHz system clock gives a 2 MHz link. Each word goes out most significant bit first. The data line changes only while the serial clock is low, so the chip samples a stable bit on each rising edge. After the 32nd bit, the strobe goes high for one serial period to latch the word into the chip. The busy output covers the whole burst. When the burst ends, the done output goes high and stays high until the next start.

Top module: `mwl_loader`

## Requirements
- R1: After reset, mw_clk, mw_data, mw_le, cfg_rd, busy and done are all low.
- R2: A start pulse while idle raises busy on the next cycle and clears done. busy never rises without a start pulse in the cycle before.
- R3: The first word of every burst is the reset word 0x80000000, shifted most significant bit first (bit 31 on the first rising edge of mw_clk).
- R4: Configuration word k (k = 0..7) is {upper, lower}. The upper half is read from address BASE+2k and the lower half from BASE+2k+1, with BASE = 0x00D by default. The eight words are sent in rising address order, the upper half is read before the lower half, and read data is taken one cycle after cfg_rd and cfg_addr are presented. mw_clk is low whenever cfg_rd is high.
- R5: While a word is shifting, mw_clk has a period of DIV system cycles: DIV/2 cycles low (rounded down), then the remaining cycles high. A word gets exactly 32 rising edges.
- R6: mw_data stays constant while mw_clk is high.
- R7: mw_le is low during the 32 bits of a word. After the 32nd bit it is high for exactly DIV cycles, and mw_clk stays low for that whole time.
- R8: Exactly nine words are latched per burst. busy then falls, and done rises in the same cycle and stays high until the next start. busy and done are never high together.
- R9: A start pulse while busy is ignored: the burst in progress continues unchanged and still ends after nine words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for one programming burst |
| cfg_rd | output | 1 | Read strobe to the configuration RAM |
| cfg_addr | output | AW (12) | Configuration RAM address |
| cfg_rdata | input | HALF_W (16) | Configuration RAM data, valid one cycle after cfg_rd |
| mw_clk | output | 1 | Serial clock to the chip |
| mw_data | output | 1 | Serial data to the chip |
| mw_le | output | 1 | Latch-enable strobe to the chip |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst finished |

## Verification
The assertions check these rules on every cycle: data holds still while the clock is high, the strobe and the clock are never high together, reads happen only while the clock is low, busy and done are mutually exclusive, busy rises only after a start pulse, and the divider and word counters stay inside their ranges. Only the bench scenarios can show the actual content and order of the words. The bench checks them with a receiver model that rebuilds each word from the line, along with the 32-bit count per word, the exact clock and strobe timings, the read addresses, the nine-word total, and that a start pulse in the middle of a burst is ignored.

// File: rtl/mwl_pkg.sv
package mwl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_FETCH_CAP,
        ST_SHIFT,
        ST_LATCH
    } mwl_state_e;

endpackage

// File: rtl/mwl_sclk_timer.sv
module mwl_sclk_timer #(
    parameter int unsigned DIV = 25,
    localparam int unsigned CW = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last,
    output logic phase_hi
);

    localparam logic [CW-1:0] TOP = CW'(DIV - 1);
    localparam logic [CW-1:0] LO_LEN = CW'(DIV / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (!run)
            d.cnt = '0;
        else if (q.cnt == TOP)
            d.cnt = '0;
        else
            d.cnt = q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign last     = run && (q.cnt == TOP);
    assign phase_hi = run && (q.cnt >= LO_LEN);

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= TOP);

endmodule

// File: rtl/mwl_addr_gen.sv
module mwl_addr_gen #(
    parameter int unsigned AW = 12,
    parameter int unsigned IW = 4,
    parameter logic [AW-1:0] BASE = 12'h00D
) (
    input  logic [IW-1:0] word_idx,
    input  logic          half,
    output logic [AW-1:0] addr
);

    // word_idx 1 maps to the first configuration pair at BASE
    localparam logic [AW-1:0] ORIGIN = BASE - AW'(2);

    always_comb begin
        addr = ORIGIN + (AW'(word_idx) << 1) + AW'(half);
    end

endmodule

// File: rtl/mwl_seq.sv
module mwl_seq
    import mwl_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned NCFG = 8,
    localparam int unsigned WORD_W = 2 * HALF_W,
    localparam int unsigned IW = $clog2(NCFG + 1),
    localparam int unsigned BW = $clog2(WORD_W),
    parameter logic [WORD_W-1:0] RESET_WORD = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick_last,
    input  logic [HALF_W-1:0] cfg_rdata,
    output logic              run,
    output logic              cfg_rd,
    output logic              half,
    output logic [IW-1:0]     word_idx,
    output logic              shifting,
    output logic              latching,
    output logic              msb,
    output logic              busy,
    output logic              done
);

    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);
    localparam logic [IW-1:0] LAST_WORD = IW'(NCFG);

    typedef struct packed {
        mwl_state_e        state;
        logic [IW-1:0]     word;
        logic [BW-1:0]     bits;
        logic [HALF_W-1:0] hi;
        logic [WORD_W-1:0] shreg;
        logic              done;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        run    = 1'b0;
        cfg_rd = 1'b0;
        half   = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_SHIFT;
                    d.word  = '0;
                    d.bits  = '0;
                    d.shreg = RESET_WORD;
                    d.done  = 1'b0;
                end
            end
            ST_FETCH_HI: begin
                cfg_rd  = 1'b1;
                d.state = ST_FETCH_LO;
            end
            ST_FETCH_LO: begin
                cfg_rd  = 1'b1;
                half    = 1'b1;
                d.hi    = cfg_rdata;
                d.state = ST_FETCH_CAP;
            end
            ST_FETCH_CAP: begin
                d.shreg = {q.hi, cfg_rdata};
                d.bits  = '0;
                d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                run = 1'b1;
                if (tick_last) begin
                    if (q.bits == LAST_BIT) begin
                        d.state = ST_LATCH;
                    end else begin
                        d.shreg = q.shreg << 1;
                        d.bits  = q.bits + BW'(1);
                    end
                end
            end
            ST_LATCH: begin
                run = 1'b1;
                if (tick_last) begin
                    if (q.word == LAST_WORD) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.word  = q.word + IW'(1);
                        d.state = ST_FETCH_HI;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign word_idx = q.word;
    assign shifting = (q.state == ST_SHIFT);
    assign latching = (q.state == ST_LATCH);
    assign msb      = q.shreg[WORD_W-1];
    assign busy     = (q.state != ST_IDLE);
    assign done     = q.done;

    a_r8_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.word <= LAST_WORD);
    a_r3_reset_word_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (q.word == '0) && (q.shreg == RESET_WORD));
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT) && (q.word != '0) |=> (q.word != '0));

endmodule

// File: rtl/mwl_loader.sv
module mwl_loader #(
    parameter int unsigned DIV = 25,
    parameter int unsigned AW = 12,
    parameter int unsigned HALF_W = 16,
    parameter int unsigned NCFG = 8,
    parameter logic [AW-1:0] BASE = 12'h00D,
    parameter logic [2*HALF_W-1:0] RESET_WORD = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cfg_rd,
    output logic [AW-1:0]     cfg_addr,
    input  logic [HALF_W-1:0] cfg_rdata,
    output logic              mw_clk,
    output logic              mw_data,
    output logic              mw_le,
    output logic              busy,
    output logic              done
);

    localparam int unsigned IW = $clog2(NCFG + 1);

    logic          run, last, phase_hi, half;
    logic          shifting, latching, msb;
    logic [IW-1:0] word_idx;

    mwl_sclk_timer #(.DIV(DIV)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .last     (last),
        .phase_hi (phase_hi)
    );

    mwl_seq #(
        .HALF_W     (HALF_W),
        .NCFG       (NCFG),
        .RESET_WORD (RESET_WORD)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tick_last (last),
        .cfg_rdata (cfg_rdata),
        .run       (run),
        .cfg_rd    (cfg_rd),
        .half      (half),
        .word_idx  (word_idx),
        .shifting  (shifting),
        .latching  (latching),
        .msb       (msb),
        .busy      (busy),
        .done      (done)
    );

    mwl_addr_gen #(.AW(AW), .IW(IW), .BASE(BASE)) u_addr (
        .word_idx (word_idx),
        .half     (half),
        .addr     (cfg_addr)
    );

    // line drivers registered so the pins carry no decode glitches
    typedef struct packed {
        logic sclk;
        logic sdata;
        logic le;
    } line_t;

    line_t q, d;

    always_comb begin
        d.sclk  = shifting && phase_hi;
        d.sdata = shifting && msb;
        d.le    = latching;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mw_clk  = q.sclk;
    assign mw_data = q.sdata;
    assign mw_le   = q.le;

    a_r7_le_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        mw_le |-> !mw_clk);
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mw_clk && $past(mw_clk) |-> $stable(mw_data));
    a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r4_read_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |-> !mw_clk);

endmodule

// File: tb/sim_mwl_loader.sv
`timescale 1ns/1ps
module sim_mwl_loader;

    localparam int DIV = 25;
    localparam int HI_LEN = DIV - DIV / 2;
    localparam logic [11:0] BASE = 12'h00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_rd;
    logic [11:0] cfg_addr;
    logic [15:0] cfg_rdata = '0;
    logic        mw_clk, mw_data, mw_le, busy, done;

    always #2.5 clk = ~clk;

    mwl_loader u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
        .mw_clk(mw_clk), .mw_data(mw_data), .mw_le(mw_le),
        .busy(busy), .done(done)
    );

    logic [15:0] mem [0:15];
    always @(posedge clk) if (cfg_rd) cfg_rdata <= mem[4'(cfg_addr - BASE)];

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // behavioural receiver model
    logic [31:0] exp_words[$];
    logic [11:0] exp_addrs[$];
    logic [31:0] rx;
    int nbits = 0, words = 0, since_rise = 0, hi_run = 0, le_run = 0;
    bit  prev_clk = 0, prev_data = 0, prev_le = 0, prev_busy = 0, seen_rise = 0;
    longint cycles = 0;

    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(0, "watchdog", cycles, 100000);
            summary();
        end
        if (rst_n) begin
            since_rise++;
            if (mw_clk) hi_run++;
            if (mw_le) le_run++;
            if (mw_clk && !prev_clk) begin
                if (seen_rise) chk(since_rise == DIV, "R5 period", since_rise, DIV);
                chk(!mw_le, "R7 le low while shifting", mw_le, 0);
                rx = {rx[30:0], mw_data};
                nbits++;
                seen_rise = 1;
                since_rise = 0;
            end
            if (mw_clk && prev_clk && mw_data != prev_data)
                chk(0, "R6 data moved while clock high", mw_data, prev_data);
            if (!mw_clk && prev_clk) begin
                chk(hi_run == HI_LEN, "R5 high time", hi_run, HI_LEN);
                hi_run = 0;
            end
            if (mw_le && mw_clk) chk(0, "R7 clock during latch", 1, 0);
            if (mw_le && !prev_le) begin
                chk(nbits == 32, "R5 32 edges per word", nbits, 32);
                if (exp_words.size() == 0) chk(0, "R8 extra word", rx, 0);
                else begin
                    logic [31:0] e;
                    e = exp_words.pop_front();
                    chk(rx == e, words == 0 ? "R3 reset word" : "R4 config word", rx, e);
                end
                words++;
                nbits = 0;
                seen_rise = 0;
            end
            if (!mw_le && prev_le) begin
                chk(le_run == DIV, "R7 latch width", le_run, DIV);
                le_run = 0;
            end
            if (cfg_rd) begin
                chk(!mw_clk, "R4 read with clock low", mw_clk, 0);
                if (exp_addrs.size() == 0) chk(0, "R4 extra read", cfg_addr, 0);
                else begin
                    logic [11:0] a;
                    a = exp_addrs.pop_front();
                    chk(cfg_addr == a, "R4 read address", cfg_addr, a);
                end
            end
            if (!busy && prev_busy) begin
                chk(words == 9, "R8 nine words", words, 9);
                chk(done, "R8 done at end", done, 1);
            end
            chk(!(busy && done), "R8 busy/done exclusive", {busy, done}, 0);
            prev_clk = mw_clk; prev_data = mw_data; prev_le = mw_le; prev_busy = busy;
        end
    end

    task automatic load_pattern(input logic [15:0] seed);
        exp_words.delete();
        exp_addrs.delete();
        for (int i = 0; i < 16; i++) mem[i] = seed ^ (16'h1357 * 16'(i + 1));
        exp_words.push_back(32'h8000_0000);
        for (int k = 0; k < 8; k++) begin
            exp_words.push_back({mem[2*k], mem[2*k+1]});
            exp_addrs.push_back(BASE + 12'(2*k));
            exp_addrs.push_back(BASE + 12'(2*k + 1));
        end
        words = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mw_clk && !mw_data && !mw_le, "R1 line idle", {mw_clk, mw_data, mw_le}, 0);
        chk(!cfg_rd && !busy && !done, "R1 status idle", {cfg_rd, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy, "R1 idle after reset", busy, 0);

        // burst 1, with a stray start mid-burst
        load_pattern(16'hA5C3);
        pulse_start();
        chk(busy, "R2 busy after start", busy, 1);
        chk(!done, "R2 done low", done, 0);
        repeat (3000) @(negedge clk);
        pulse_start();
        chk(busy, "R9 start while busy ignored", busy, 1);
        wait_idle();
        chk(exp_words.size() == 0, "R9 all words sent once", exp_words.size(), 0);
        chk(exp_addrs.size() == 0, "R4 all reads made", exp_addrs.size(), 0);
        chk(words == 9, "R9 nine words despite stray start", words, 9);
        chk(done, "R8 done held", done, 1);
        repeat (20) @(negedge clk);
        chk(done && !busy, "R8 done sticky", {busy, done}, 1);

        // burst 2, inverted pattern
        load_pattern(16'h5A3C);
        pulse_start();
        chk(!done, "R2 done cleared by start", done, 1'b0);
        chk(busy, "R2 busy burst 2", busy, 1);
        wait_idle();
        chk(exp_words.size() == 0, "R4 burst 2 words", exp_words.size(), 0);
        chk(words == 9, "R8 burst 2 count", words, 9);
        summary();
    end

endmodule